// File: doc/BRIEF.md
# Recovered-Clock Loss Detector with Reference Fallback

This block watches a recovered receive clock from the reference clock domain. The monitored clock is passed through a synchroniser, and every change of level in the synchronised copy counts as a sign of life. If twenty-three reference cycles pass with no such change, a loss flag is raised. While the flag is high and fallback is enabled, the bit strobe comes from a free-running divide-by-four of the reference clock, and the outgoing payload byte is replaced by a programmable fill pattern.

When the flag is low, the bit strobe is one reference cycle wide and marks each rising edge of the synchronised recovered clock. The payload byte passes through unchanged. The first transition seen after a loss clears the flag, and timing returns to the recovered clock. The logic that consumes the strobe and the byte sits outside this block.

Top module: `rxclk_loss_fallback`

## Requirements
- R1: `loss_flag` rises once 23 consecutive reference cycles pass with no detected transition. If transitions are detected exactly 23 cycles apart, the flag never rises. If they are 24 cycles apart, it does rise.
- R2: Any detected transition restarts the timeout. The flag falls at the first detected transition after a loss.
- R3: A change on `mon_clk` reaches the detector through two synchroniser flops. A change driven before reference edge k leaves `loss_flag` unchanged after edges k and k+1, and clears it after edge k+2.
- R4: When `fallback_en` is 0, `loss_flag` is still reported. `bit_stb` stays low unless the recovered clock rises, and `byte_out` equals `rx_byte`.
- R5: While `loss_flag` and `fallback_en` are both 1, `bit_stb` is high in exactly those cycles where the number of reference edges since reset release, taken modulo 4, equals 3. The divider runs freely from reset.
- R6: While `loss_flag` and `fallback_en` are both 1, `byte_out` equals `fill_byte`.
- R7: Without fallback, `bit_stb` is high for one reference cycle. This happens after edge k+1, where a rising edge of `mon_clk` was driven before reference edge k.
- R8: During reset, `loss_flag` and `bit_stb` are 0. After reset release with `mon_clk` held low, `loss_flag` stays 0 through edge 22 and is 1 after edge 23, which shows that the counter starts from zero.
- R9: Once the flag has cleared, a new rising edge of the recovered clock drives `bit_stb`, and `byte_out` follows `rx_byte` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_clk | input | 1 | Recovered clock under watch (asynchronous) |
| fallback_en | input | 1 | Allows fallback timing and fill when loss is flagged |
| fill_byte | input | 8 | Pattern substituted for the payload during fallback |
| rx_byte | input | 8 | Payload byte on the recovered path |
| loss_flag | output | 1 | Recovered clock judged lost |
| bit_stb | output | 1 | One-cycle bit timing strobe |
| byte_out | output | 8 | Selected payload byte |

## Verification
A detected transition and the timeout reaching its limit can fall in the same reference cycle. In that cycle the transition must win: the counter restarts and no loss is declared. The bench provokes this by toggling the monitored clock every 23 reference cycles, which puts each synchronised edge exactly on the cycle where the counter would otherwise expire. Any flag seen after the first two toggles is a miscompare. A second run with 24-cycle spacing must raise the flag, which shows the boundary sits exactly between the two spacings.

// File: rtl/lossdet_pkg.sv
package lossdet_pkg;
   // which source currently paces the bit strobe
   typedef enum logic {
      SRC_RECOVERED = 1'b0,
      SRC_REFERENCE = 1'b1
   } timing_src_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sync_chain needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/activity_monitor.sv
module activity_monitor #(
   parameter int TIMEOUT     = 23,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_clk,
   output logic loss,
   output logic rise_pulse,
   output logic fall_pulse
);
   localparam int CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] LIM    = CW'(TIMEOUT);
   localparam logic [CW-1:0] LIM_M1 = CW'(TIMEOUT - 1);

   generate
      if (TIMEOUT < 2) begin : g_bad
         $error("activity_monitor TIMEOUT must be at least 2");
      end
   endgenerate

   logic          s_q;
   logic          s_prev;
   logic          edge_seen;
   logic [CW-1:0] quiet_cnt;

   sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (mon_clk),
      .q    (s_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_q;
   end

   assign edge_seen  = s_q ^ s_prev;
   assign rise_pulse = s_q & ~s_prev;
   assign fall_pulse = ~s_q & s_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
         loss      <= 1'b0;
      end else if (edge_seen) begin
         quiet_cnt <= '0;
         loss      <= 1'b0;
      end else begin
         if (quiet_cnt != LIM)    quiet_cnt <= quiet_cnt + 1'b1;
         if (quiet_cnt == LIM_M1) loss      <= 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_cnt <= LIM); // R1
   AST_LOSS_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loss) |-> ($past(quiet_cnt) == LIM_M1 && !$past(edge_seen))); // R1
   AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> (!loss && quiet_cnt == '0)); // R2
   AST_LOSS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (loss && !edge_seen) |=> loss); // R2
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad
         $error("ref_divider DIV must be at least 2");
      end
   endgenerate

   logic [DW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R5
endmodule

// File: rtl/rxclk_loss_fallback.sv
module rxclk_loss_fallback
   import lossdet_pkg::*;
#(
   parameter int TIMEOUT        = 23,
   parameter int DIV            = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int BYTE_W         = 8,
   parameter bit STROBE_ON_RISE = 1'b1
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              mon_clk,
   input  logic              fallback_en,
   input  logic [BYTE_W-1:0] fill_byte,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              loss_flag,
   output logic              bit_stb,
   output logic [BYTE_W-1:0] byte_out
);
   generate
      if (BYTE_W < 1) begin : g_bad
         $error("rxclk_loss_fallback BYTE_W must be positive");
      end
   endgenerate

   logic        rise_p;
   logic        fall_p;
   logic        rec_stb;
   logic        div_tick;
   timing_src_e src;

   activity_monitor #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .mon_clk   (mon_clk),
      .loss      (loss_flag),
      .rise_pulse(rise_p),
      .fall_pulse(fall_p)
   );

   ref_divider #(.DIV(DIV)) u_div (
      .clk  (ref_clk),
      .rst_n(rst_n),
      .tick (div_tick)
   );

   generate
      if (STROBE_ON_RISE) begin : g_rise
         assign rec_stb = rise_p;
      end else begin : g_fall
         assign rec_stb = fall_p;
      end
   endgenerate

   assign src      = (loss_flag && fallback_en) ? SRC_REFERENCE : SRC_RECOVERED;
   assign bit_stb  = (src == SRC_REFERENCE) ? div_tick : rec_stb;
   assign byte_out = (src == SRC_REFERENCE) ? fill_byte : rx_byte;

   AST_DISABLED_NO_REF: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!fallback_en && !rise_p && !fall_p) |-> !bit_stb); // R4
   AST_NO_LOSS_NO_FILL: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!loss_flag && !rise_p && !fall_p) |-> !bit_stb); // R7
endmodule

// File: tb/rxclk_loss_fallback_test.sv
module rxclk_loss_fallback_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mon;
   logic       en;
   logic [7:0] fill;
   logic [7:0] rx;
   logic       loss_flag;
   logic       bit_stb;
   logic [7:0] byte_out;

   int nchk  = 0;
   int nfail = 0;
   int cyc   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   rxclk_loss_fallback uut (
      .ref_clk    (clk),
      .rst_n      (rst_n),
      .mon_clk    (mon),
      .fallback_en(en),
      .fill_byte  (fill),
      .rx_byte    (rx),
      .loss_flag  (loss_flag),
      .bit_stb    (bit_stb),
      .byte_out   (byte_out)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; mon = 1'b0; en = 1'b1; fill = 8'hA5; rx = 8'h3C;
      step(3);
      check("R8", "loss in reset", loss_flag, 0);
      check("R8", "strobe in reset", bit_stb, 0);
      check("R8", "byte in reset", byte_out, rx);
      rst_n = 1'b1;
      step(22);
      check("R8", "loss after 22 quiet", loss_flag, 0);
      step(1);
      check("R8", "loss after 23 quiet", loss_flag, 1);
   endtask

   task automatic t_fallback();
      for (int i = 0; i < 12; i++) begin
         check("R5", "div4 strobe", bit_stb, ((cyc % 4) == 3) ? 1 : 0);
         check("R6", "fill byte", byte_out, fill);
         step(1);
      end
   endtask

   task automatic t_recover();
      mon = 1'b1;
      step(1);
      check("R3", "loss after edge k", loss_flag, 1);
      step(1);
      check("R3", "loss after edge k+1", loss_flag, 1);
      step(1);
      check("R2", "loss cleared after k+2", loss_flag, 0);
      mon = 1'b0;
      step(3);
      rx = 8'h5E;
      mon = 1'b1;
      step(1);
      check("R7", "no strobe after edge k", bit_stb, 0);
      step(1);
      check("R9", "recovered strobe", bit_stb, 1);
      check("R9", "payload byte", byte_out, 8'h5E);
      step(1);
      check("R7", "strobe one cycle", bit_stb, 0);
   endtask

   task automatic t_spacing(int n, bit expect_loss);
      int seen = 0;
      for (int t = 0; t < 6; t++) begin
         mon = ~mon;
         for (int c = 0; c < n; c++) begin
            step(1);
            if (t >= 2 && loss_flag) seen++;
         end
      end
      check("R1", $sformatf("loss seen at spacing %0d", n), (seen > 0) ? 1 : 0, expect_loss ? 1 : 0);
   endtask

   task automatic t_disabled();
      en = 1'b0; rx = 8'h81;
      step(30);
      check("R4", "loss reported while disabled", loss_flag, 1);
      for (int i = 0; i < 8; i++) begin
         check("R4", "no strobe while disabled", bit_stb, 0);
         check("R4", "payload while disabled", byte_out, 8'h81);
         step(1);
      end
      en = 1'b1;
      step(1);
      check("R6", "fill once enabled", byte_out, fill);
   endtask

   initial begin
      t_reset();
      t_fallback();
      t_recover();
      t_spacing(23, 1'b0);
      t_spacing(24, 1'b1);
      t_disabled();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule